// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a 32-bit interval timer for a memory-mapped peripheral. It holds three word registers behind a small register port: a control word, a compare value and a live counter. Once software sets the enable bit, the counter advances by one on every clock until it equals the compare value. The timer then emits a one-cycle interrupt pulse and, depending on the autorestart bit, either clears its own enable bit and parks, or starts again from zero.

Software can preload the counter before enabling, freeze it by clearing the enable bit, and read back the elapsed count at any time. A register write that lands on the same edge as a compare hit takes precedence over the hardware update of that register. Two instances are meant to sit side by side in one register bank. Bus protocol conversion, interrupt routing and clock generation are handled elsewhere.

Top module: `upcount_timer`

## Requirements
- R1: Word address 0 selects control, 1 selects compare, 2 selects counter; address 3 reads as zero and writes to it change nothing. In the control word bit 0 enables counting and bit 1 selects autorestart; all other control bits are stored and read back but have no effect.
- R2: While enabled and not at a hit, the counter rises by exactly one per clock, and a read of address 2 returns the current count.
- R3: A write to the counter preloads it; a later control write with bit 0 set resumes counting from the preloaded value.
- R4: A control write with bit 0 clear stops the counter, which then holds its value.
- R5: A hit occurs on an edge where the timer is enabled and the counter equals compare; with autorestart clear, that edge clears control bit 0 and the counter stays at the compare value.
- R6: Each hit drives irq high for the single cycle after the hit edge, in both modes; the first pulse appears compare minus preload plus one cycles after the enabling write.
- R7: Reset sets control, compare, counter and irq to zero.
- R8: With autorestart set, a hit reloads the counter to zero and leaves bit 0 set, so later pulses come every compare plus one cycles.
- R9: A register write on the same edge as a hit wins over the hardware update of that register, and the interrupt pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | One-cycle interrupt pulse per hit |

## Verification
A register write takes effect on the edge it is presented at, while read data follows addr combinationally, so the bench samples one nanosecond after an edge and sets the read address between edges. The counter is one register stage, so after an enabling write it shows preload plus k after k edges, and irq, registered from the hit, rises compare minus preload plus one edges after the enable. The bench counts edges from the enabling write to the pulse against that figure, and for the priority cases it schedules a write to land exactly on the computed hit edge before reading back the register it contested.

// File: rtl/uptmr_pkg.sv
package uptmr_pkg;

    localparam int TMR_W  = 32;
    localparam int ADDR_W = 2;

    // control bit positions
    localparam int EN_BIT = 0;
    localparam int AR_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CNT   = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic cmp;
        logic cnt;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.ctrl = we && (reg_sel_e'(a) == SEL_CTRL);
        s.cmp  = we && (reg_sel_e'(a) == SEL_CMP);
        s.cnt  = we && (reg_sel_e'(a) == SEL_CNT);
        return s;
    endfunction

endpackage

// File: rtl/uptmr_regs.sv
module uptmr_regs
    import uptmr_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       stb,
    input  logic [W-1:0]     wr_data,
    input  logic             hw_clr_en,
    output logic [W-1:0]     ctrl_q,
    output logic [W-1:0]     cmp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (stb.ctrl)
                ctrl_q <= wr_data;
            else if (hw_clr_en)
                ctrl_q[EN_BIT] <= 1'b0;
            if (stb.cmp)
                cmp_q <= wr_data;
        end
    end

    // R7: registers are zero the edge after reset
    a_r7_regs_reset: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && cmp_q == '0));

    // R9: a software control write beats the hardware enable clear
    a_r9_ctrl_write_wins: assert property (@(posedge clk) disable iff (rst)
        stb.ctrl |=> ctrl_q == $past(wr_data));

endmodule

// File: rtl/uptmr_core.sv
module uptmr_core
    import uptmr_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         autorestart,
    input  logic [W-1:0] cmp,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         irq,
    output logic         hw_clr_en
);

    logic hit;

    assign hit       = enable && (cnt_q == cmp);
    assign hw_clr_en = hit && !autorestart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= hit;
            if (cnt_wr)
                cnt_q <= wr_data;
            else if (hit) begin
                if (autorestart)
                    cnt_q <= '0;
            end else if (enable)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: one step per clock while running
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (enable && cnt_q != cmp && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R4: a stopped counter holds
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!enable && !cnt_wr) |=> $stable(cnt_q));

    // R6: every hit yields a pulse on the next cycle
    a_r6_pulse_after_hit: assert property (@(posedge clk) disable iff (rst)
        (enable && cnt_q == cmp) |=> irq);

    // R8: autorestart reloads to zero
    a_r8_reload_zero: assert property (@(posedge clk) disable iff (rst)
        (enable && autorestart && cnt_q == cmp && !cnt_wr) |=> cnt_q == '0);

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import uptmr_pkg::*;
#(
    parameter int W  = TMR_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          irq
);

    wr_strobe_t   stb;
    logic [W-1:0] ctrl_q;
    logic [W-1:0] cmp_q;
    logic [W-1:0] cnt_q;
    logic         hw_clr_en;

    assign stb = decode_wr(wr_en, addr);

    uptmr_regs #(.W(W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb),
        .wr_data   (wr_data),
        .hw_clr_en (hw_clr_en),
        .ctrl_q    (ctrl_q),
        .cmp_q     (cmp_q)
    );

    uptmr_core #(.W(W)) core_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (ctrl_q[EN_BIT]),
        .autorestart (ctrl_q[AR_BIT]),
        .cmp         (cmp_q),
        .cnt_wr      (stb.cnt),
        .wr_data     (wr_data),
        .cnt_q       (cnt_q),
        .irq         (irq),
        .hw_clr_en   (hw_clr_en)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_CTRL: rd_data = ctrl_q;
            SEL_CMP:  rd_data = cmp_q;
            SEL_CNT:  rd_data = cnt_q;
            default:  rd_data = '0;
        endcase
    end

    // R5: a one-shot hit drops the enable bit and parks the counter
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[EN_BIT] && !ctrl_q[AR_BIT] && cnt_q == cmp_q && !stb.ctrl && !stb.cnt)
        |=> (!ctrl_q[EN_BIT] && cnt_q == $past(cmp_q)));

    // R7: output quiet after reset
    a_r7_irq_reset: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/upcount_timer_tb_top.sv
module upcount_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    upcount_timer dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    localparam int NV = 6;
    localparam logic [31:0] V_PRE [NV] = '{32'd0, 32'd3, 32'd0, 32'd7, 32'd0, 32'd2};
    localparam logic [31:0] V_CMP [NV] = '{32'd5, 32'd10, 32'd0, 32'd7, 32'd4, 32'd6};
    localparam bit          V_AR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [31:0] EXTRA = 32'hA5A5_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    // edges until irq is seen, sampled 1 ns after each edge
    task automatic wait_irq(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            #1;
            n++;
            if (irq) break;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7 reset state
        rd(2'd0, v); chk("R7 ctrl", v, 32'd0);
        rd(2'd1, v); chk("R7 cmp", v, 32'd0);
        rd(2'd2, v); chk("R7 cnt", v, 32'd0);
        chk("R7 irq", {31'd0, irq}, 32'd0);

        // vector table: R3 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'd0);
            wr(2'd1, V_CMP[i]);
            wr(2'd2, V_PRE[i]);
            wr(2'd0, EXTRA | {30'd0, V_AR[i], 1'b1});
            wait_irq(n);
            chk($sformatf("R6 first pulse v%0d", i), n, V_CMP[i] - V_PRE[i] + 1);
            if (!V_AR[i]) begin
                rd(2'd0, v); chk($sformatf("R5 enable cleared v%0d", i), v, EXTRA);
                rd(2'd2, v); chk($sformatf("R5 count parked v%0d", i), v, V_CMP[i]);
                @(posedge clk); #1;
                chk($sformatf("R6 single cycle v%0d", i), {31'd0, irq}, 32'd0);
                rd(2'd2, v); chk($sformatf("R5 still parked v%0d", i), v, V_CMP[i]);
            end else begin
                rd(2'd2, v); chk($sformatf("R8 reload v%0d", i), v, 32'd0);
                rd(2'd0, v); chk($sformatf("R8 enable kept v%0d", i), v, EXTRA | 32'd3);
                @(posedge clk); #1;
                chk($sformatf("R6 single cycle v%0d", i), {31'd0, irq}, 32'd0);
                n = 1;
                for (int k = 0; k < 200; k++) begin
                    if (irq) break;
                    @(posedge clk); #1; n++;
                end
                chk($sformatf("R8 period v%0d", i), n, V_CMP[i] + 1);
                wr(2'd0, 32'd0);
            end
        end

        // R2 R4 stop and resume
        wr(2'd0, 32'd0); wr(2'd1, 32'd100); wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        repeat (5) @(posedge clk);
        wr(2'd0, 32'd0);
        rd(2'd2, v); chk("R2 count at stop", v, 32'd6);
        repeat (5) @(posedge clk);
        #1;
        rd(2'd2, v); chk("R4 held", v, 32'd6);
        wr(2'd0, 32'd1);
        rd(2'd2, v); chk("R3 resume value", v, 32'd6);
        repeat (3) @(posedge clk);
        #1;
        rd(2'd2, v); chk("R2 counting resumed", v, 32'd9);
        wr(2'd0, 32'd0);

        // R9 control write on the hit edge
        wr(2'd1, 32'd4); wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        repeat (4) @(posedge clk);
        wr(2'd0, 32'd3);
        chk("R9 irq on contested hit", {31'd0, irq}, 32'd1);
        rd(2'd0, v); chk("R9 ctrl write wins", v, 32'd3);
        rd(2'd2, v); chk("R9 count held", v, 32'd4);
        wr(2'd0, 32'd0);

        // R9 counter write on the hit edge
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd3);
        repeat (4) @(posedge clk);
        wr(2'd2, 32'd9);
        chk("R9 irq on counter write", {31'd0, irq}, 32'd1);
        rd(2'd2, v); chk("R9 counter write wins", v, 32'd9);
        wr(2'd0, 32'd0);

        // R1 spare address and inert control bits
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R1 spare reads zero", v, 32'd0);
        rd(2'd0, v); chk("R1 ctrl untouched", v, 32'd0);
        rd(2'd1, v); chk("R1 cmp untouched", v, 32'd4);
        wr(2'd2, 32'd2);
        wr(2'd0, 32'hFFFF_FFFC);
        repeat (4) @(posedge clk);
        #1;
        rd(2'd2, v); chk("R1 upper bits inert", v, 32'd2);
        rd(2'd0, v); chk("R1 upper bits stored", v, 32'hFFFF_FFFC);

        // R7 reset mid-run
        wr(2'd0, 32'd1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        rd(2'd0, v); chk("R7 ctrl after run", v, 32'd0);
        rd(2'd2, v); chk("R7 cnt after run", v, 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule